// File: doc/BRIEF.md
# Branch Next-PC Resolver

This block works out where an 8-bit accumulator core fetches next when it meets a branch. The decoder gives it the address of the instruction that follows the branch, a 4-bit branch kind code and the operands that kind needs. These are an 11-bit in-page address, a 16-bit long address, a signed 8-bit displacement, the accumulator, the 16-bit data pointer, the carry flag, a tested bit, two compare bytes and a byte to decrement. One cycle later the block returns the next program counter and a taken flag. It also returns the side results of the branch: the decremented byte, a carry update for compare branches, and a request to clear the tested bit.

A small state machine controls when results are visible. It has two states. `ST_IDLE` means no result is being presented. `ST_SHOW` means the output registers hold the result of the request from the previous cycle. The transition `T_ACCEPT` goes from `ST_IDLE` to `ST_SHOW` when `req_valid` is high. The transition `T_CHAIN` stays in `ST_SHOW` when another request arrives at once. The transition `T_DRAIN` goes from `ST_SHOW` back to `ST_IDLE` when no request arrives. The strobes `taken`, `carry_wr` and `bit_clear` are high only in a cycle where `res_valid` is high. The stack push for calls, instruction fetch and decode all belong to other blocks.

Top module: `bnpc_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request, `res_valid`, `taken`, `carry_wr` and `bit_clear` are 0 and `target_pc` is 0.
- R2: A request with `req_valid` high at a clock edge gives `res_valid` high exactly after the next edge. A cycle with no request gives `res_valid` low one cycle later, and back-to-back requests give back-to-back results.
- R3: Kind 1 (in-page jump or call) is always taken. The target keeps bits 15..11 of `next_pc` and takes bits 10..0 from `page_addr`, so it never leaves the 2 KB block of the following instruction.
- R4: Kind 2 (long jump or call) is always taken, with target equal to `long_addr`.
- R5: Kind 3 (short relative) is always taken. The target is `next_pc` plus the sign-extended two's-complement `rel_off`, wrapping modulo 65536, which gives a reach of 128 back to 127 forward.
- R6: Kind 4 (indirect) is always taken. The target is `dptr` plus the zero-extended `acc`, modulo 65536. No carry update or bit clear is requested.
- R7: Kind 5 is taken when `carry_in` is 1 and kind 6 when `carry_in` is 0. Both target `next_pc` plus the sign-extended `rel_off`.
- R8: Kinds 7 and 9 are taken when `test_bit` is 1 and kind 8 when it is 0, with a relative target. `bit_clear` rises only for kind 9 when it is taken.
- R9: Kind 10 is taken when `acc` is 0x00 and kind 11 when `acc` is not 0x00, with a relative target.
- R10: Kind 12 (compare) is taken when `cmp_a` differs from `cmp_b`, with a relative target. It raises `carry_wr` with `carry_out` = 1 when `cmp_a` < `cmp_b` unsigned, and 0 otherwise. It raises `carry_wr` whether or not the branch is taken. No other kind raises `carry_wr`.
- R11: Kind 13 (decrement) returns `dec_result` = `dec_src` − 1 modulo 256. It is taken only when that result is not zero, so 0x01 falls through and 0x00 becomes 0xFF and branches.
- R12: A branch that is not taken gives `target_pc` = `next_pc`. Kind 0 and the unused codes 14 and 15 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A branch is presented this cycle |
| br_kind | input | 4 | Branch kind code (see R3–R12) |
| next_pc | input | 16 | Address of the following instruction |
| page_addr | input | 11 | In-page target bits |
| long_addr | input | 16 | Full target address |
| rel_off | input | 8 | Signed displacement |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| carry_in | input | 1 | Current carry flag |
| test_bit | input | 1 | Value of the addressed bit |
| cmp_a | input | 8 | First compare operand |
| cmp_b | input | 8 | Second compare operand |
| dec_src | input | 8 | Byte to decrement |
| res_valid | output | 1 | Result registers are valid |
| taken | output | 1 | Branch taken |
| target_pc | output | 16 | Next program counter |
| dec_result | output | 8 | Decremented byte |
| carry_wr | output | 1 | Carry update requested |
| carry_out | output | 1 | New carry value |
| bit_clear | output | 1 | Clear the tested bit |

## Verification
The hardest cases to reach are the address wrap cases. One is a relative target that crosses 0xFFFF into 0x0000, or falls below 0x0000. Another is an in-page splice where `next_pc` sits exactly on the first byte of a new 2 KB block. A third is the decrement of 0x00 wrapping to 0xFF. Random operands almost never land on these, so the random mix is followed by directed requests that place `next_pc`, `dptr` and the operands on those boundaries. Back-to-back requests are also made so that the `T_CHAIN` transition is exercised alongside `T_ACCEPT` and `T_DRAIN`.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

    typedef enum logic [3:0] {
        BK_NONE  = 4'd0,
        BK_PAGE  = 4'd1,
        BK_LONG  = 4'd2,
        BK_REL   = 4'd3,
        BK_IND   = 4'd4,
        BK_CY1   = 4'd5,
        BK_CY0   = 4'd6,
        BK_BIT1  = 4'd7,
        BK_BIT0  = 4'd8,
        BK_BITC  = 4'd9,
        BK_AZ    = 4'd10,
        BK_ANZ   = 4'd11,
        BK_CMP   = 4'd12,
        BK_DEC   = 4'd13,
        BK_RSV14 = 4'd14,
        BK_RSV15 = 4'd15
    } br_kind_e;

    typedef enum logic [1:0] {
        TSEL_FALL = 2'd0,
        TSEL_PAGE = 2'd1,
        TSEL_LONG = 2'd2,
        TSEL_ALT  = 2'd3
    } tsel_e;

endpackage

// File: rtl/bnpc_target_gen.sv
module bnpc_target_gen #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 11
) (
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [DATA_W-1:0] rel_off,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] dptr,
    output logic [ADDR_W-1:0] page_tgt,
    output logic [ADDR_W-1:0] rel_tgt,
    output logic [ADDR_W-1:0] ind_tgt
);
    localparam int EXT_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] off_sx;
    logic [ADDR_W-1:0] acc_zx;

    always_comb begin
        off_sx   = {{EXT_W{rel_off[DATA_W-1]}}, rel_off};
        acc_zx   = {{EXT_W{1'b0}}, acc};
        page_tgt = {next_pc[ADDR_W-1:PAGE_W], page_addr};
        rel_tgt  = next_pc + off_sx;
        ind_tgt  = dptr + acc_zx;
    end
endmodule

// File: rtl/bnpc_cond_eval.sv
module bnpc_cond_eval
    import bnpc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  br_kind_e          kind,
    input  logic              carry_in,
    input  logic              test_bit,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic [DATA_W-1:0] dec_src,
    output logic              take,
    output tsel_e             tsel,
    output logic              alt_ind,
    output logic [DATA_W-1:0] dec_val,
    output logic              cy_wr,
    output logic              cy_val,
    output logic              clr_bit
);
    logic acc_zero;
    logic dec_zero;

    always_comb begin
        dec_val  = dec_src - {{(DATA_W-1){1'b0}}, 1'b1};
        acc_zero = (acc == '0);
        dec_zero = (dec_val == '0);
        take     = 1'b0;
        tsel     = TSEL_ALT;
        alt_ind  = 1'b0;
        cy_wr    = 1'b0;
        cy_val   = 1'b0;
        clr_bit  = 1'b0;
        unique case (kind)
            BK_PAGE: begin take = 1'b1; tsel = TSEL_PAGE; end
            BK_LONG: begin take = 1'b1; tsel = TSEL_LONG; end
            BK_REL:  take = 1'b1;
            BK_IND:  begin take = 1'b1; alt_ind = 1'b1; end
            BK_CY1:  take = carry_in;
            BK_CY0:  take = ~carry_in;
            BK_BIT1: take = test_bit;
            BK_BIT0: take = ~test_bit;
            BK_BITC: begin take = test_bit; clr_bit = test_bit; end
            BK_AZ:   take = acc_zero;
            BK_ANZ:  take = ~acc_zero;
            BK_CMP: begin
                take   = (cmp_a != cmp_b);
                cy_wr  = 1'b1;
                cy_val = (cmp_a < cmp_b);
            end
            BK_DEC:  take = ~dec_zero;
            default: take = 1'b0;
        endcase
        if (!take) tsel = TSEL_FALL;
    end
endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
    import bnpc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        br_kind,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [ADDR_W-1:0] long_addr,
    input  logic [DATA_W-1:0] rel_off,
    input  logic [DATA_W-1:0] acc,
    input  logic [ADDR_W-1:0] dptr,
    input  logic              carry_in,
    input  logic              test_bit,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic [DATA_W-1:0] dec_src,
    output logic              res_valid,
    output logic              taken,
    output logic [ADDR_W-1:0] target_pc,
    output logic [DATA_W-1:0] dec_result,
    output logic              carry_wr,
    output logic              carry_out,
    output logic              bit_clear
);
    localparam int HI_W = ADDR_W - PAGE_W;

    typedef enum logic {ST_IDLE = 1'b0, ST_SHOW = 1'b1} st_e;

    st_e state_q, state_d;

    br_kind_e          kind;
    logic [ADDR_W-1:0] page_tgt, rel_tgt, ind_tgt;
    logic              take, alt_ind, cy_wr, cy_val, clr_bit;
    tsel_e             tsel;
    logic [DATA_W-1:0] dec_val;
    logic [ADDR_W-1:0] tgt_mux;

    assign kind = br_kind_e'(br_kind);

    bnpc_target_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) tgen_i (
        .next_pc   (next_pc),
        .page_addr (page_addr),
        .rel_off   (rel_off),
        .acc       (acc),
        .dptr      (dptr),
        .page_tgt  (page_tgt),
        .rel_tgt   (rel_tgt),
        .ind_tgt   (ind_tgt)
    );

    bnpc_cond_eval #(.DATA_W(DATA_W)) cond_i (
        .kind     (kind),
        .carry_in (carry_in),
        .test_bit (test_bit),
        .acc      (acc),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .dec_src  (dec_src),
        .take     (take),
        .tsel     (tsel),
        .alt_ind  (alt_ind),
        .dec_val  (dec_val),
        .cy_wr    (cy_wr),
        .cy_val   (cy_val),
        .clr_bit  (clr_bit)
    );

    always_comb begin
        unique case (tsel)
            TSEL_PAGE: tgt_mux = page_tgt;
            TSEL_LONG: tgt_mux = long_addr;
            TSEL_ALT:  tgt_mux = alt_ind ? ind_tgt : rel_tgt;
            default:   tgt_mux = next_pc;
        endcase
    end

    // Transitions: T_ACCEPT (IDLE->SHOW), T_CHAIN (SHOW->SHOW), T_DRAIN (SHOW->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_SHOW;
            ST_SHOW: if (!req_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken      <= 1'b0;
            target_pc  <= '0;
            dec_result <= '0;
            carry_wr   <= 1'b0;
            carry_out  <= 1'b0;
            bit_clear  <= 1'b0;
        end else if (req_valid) begin
            taken      <= take;
            target_pc  <= tgt_mux;
            dec_result <= dec_val;
            carry_wr   <= cy_wr;
            carry_out  <= cy_val;
            bit_clear  <= clr_bit;
        end else begin
            taken      <= 1'b0;
            carry_wr   <= 1'b0;
            bit_clear  <= 1'b0;
        end
    end

    assign res_valid = (state_q == ST_SHOW);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    assert_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    assert_page_splice_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && br_kind == 4'd1) |=>
        (target_pc[ADDR_W-1:PAGE_W] == $past(next_pc[ADDR_W-1:PAGE_W]))
        && (target_pc[PAGE_W-1:0] == $past(page_addr)) && (HI_W > 0));
    assert_fallthrough_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !taken) |-> target_pc == $past(next_pc));
    assert_bitclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clear |-> (taken && res_valid));
    assert_carry_only_cmp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        carry_wr |-> (res_valid && $past(br_kind) == 4'd12));
endmodule

// File: tb/bnpc_unit_tb.sv
module bnpc_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  br_kind = '0;
    logic [15:0] next_pc = '0, long_addr = '0, dptr = '0;
    logic [10:0] page_addr = '0;
    logic [7:0]  rel_off = '0, acc = '0, cmp_a = '0, cmp_b = '0, dec_src = '0;
    logic        carry_in = 1'b0, test_bit = 1'b0;
    logic        res_valid, taken, carry_wr, carry_out, bit_clear;
    logic [15:0] target_pc;
    logic [7:0]  dec_result;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    bnpc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .br_kind(br_kind),
        .next_pc(next_pc), .page_addr(page_addr), .long_addr(long_addr),
        .rel_off(rel_off), .acc(acc), .dptr(dptr), .carry_in(carry_in),
        .test_bit(test_bit), .cmp_a(cmp_a), .cmp_b(cmp_b), .dec_src(dec_src),
        .res_valid(res_valid), .taken(taken), .target_pc(target_pc),
        .dec_result(dec_result), .carry_wr(carry_wr), .carry_out(carry_out),
        .bit_clear(bit_clear)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rel_of(input logic [15:0] pc, input logic [7:0] off);
        int s;
        s = int'(pc) + int'($signed(off));
        return 16'(s & 32'hFFFF);
    endfunction

    function automatic logic exp_take(input logic [3:0] k);
        case (k)
            4'd1, 4'd2, 4'd3, 4'd4: return 1'b1;
            4'd5:  return carry_in;
            4'd6:  return !carry_in;
            4'd7, 4'd9: return test_bit;
            4'd8:  return !test_bit;
            4'd10: return acc == 8'h00;
            4'd11: return acc != 8'h00;
            4'd12: return cmp_a != cmp_b;
            4'd13: return dec_src != 8'h01;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] exp_tgt(input logic [3:0] k);
        if (!exp_take(k)) return next_pc;
        case (k)
            4'd1: return {next_pc[15:11], page_addr};
            4'd2: return long_addr;
            4'd4: return 16'((32'(dptr) + 32'(acc)) & 32'hFFFF);
            default: return rel_of(next_pc, rel_off);
        endcase
    endfunction

    function automatic string rtag(input logic [3:0] k);
        case (k)
            4'd1: return "R3";  4'd2: return "R4";  4'd3: return "R5";
            4'd4: return "R6";  4'd5, 4'd6: return "R7";
            4'd7, 4'd8, 4'd9: return "R8";
            4'd10, 4'd11: return "R9"; 4'd12: return "R10";
            4'd13: return "R11"; default: return "R12";
        endcase
    endfunction

    // Drives one request at a negedge, checks the result one negedge later.
    task automatic issue(input logic [3:0] k);
        logic        e_take;
        logic [15:0] e_tgt;
        br_kind   = k;
        req_valid = 1'b1;
        e_take    = exp_take(k);
        e_tgt     = exp_tgt(k);
        @(negedge clk);
        chk("R2 res_valid", 32'(res_valid), 32'd1);
        chk({rtag(k), " taken"}, 32'(taken), 32'(e_take));
        chk({rtag(k), " target"}, 32'(target_pc), 32'(e_tgt));
        if (!e_take) chk("R12 fallthrough", 32'(target_pc), 32'(next_pc));
        chk("R10 carry_wr", 32'(carry_wr), 32'(k == 4'd12));
        if (k == 4'd12) chk("R10 carry_out", 32'(carry_out), 32'(cmp_a < cmp_b));
        chk("R8 bit_clear", 32'(bit_clear), 32'(k == 4'd9 && test_bit));
        if (k == 4'd13) chk("R11 dec_result", 32'(dec_result), 32'(8'(dec_src - 8'd1)));
        req_valid = 1'b0;
    endtask

    task automatic randomize_ops();
        next_pc   = 16'($urandom);
        page_addr = 11'($urandom);
        long_addr = 16'($urandom);
        rel_off   = 8'($urandom);
        acc       = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
        dptr      = 16'($urandom);
        carry_in  = 1'($urandom);
        test_bit  = 1'($urandom);
        cmp_a     = 8'($urandom);
        cmp_b     = ($urandom % 3 == 0) ? cmp_a : 8'($urandom);
        dec_src   = 8'($urandom % 4);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R1 res_valid in reset", 32'(res_valid), 32'd0);
        chk("R1 target in reset", 32'(target_pc), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 res_valid after reset", 32'(res_valid), 32'd0);
        chk("R1 taken after reset", 32'(taken), 32'd0);
        chk("R1 strobes after reset", 32'({carry_wr, bit_clear}), 32'd0);

        // Directed corner cases
        next_pc = 16'h0800; page_addr = 11'h7FF; issue(4'd1);      // R3 page start
        next_pc = 16'hF800; page_addr = 11'h123; issue(4'd1);      // R3
        long_addr = 16'hBEEF; issue(4'd2);                         // R4
        next_pc = 16'hFFF0; rel_off = 8'h7F; issue(4'd3);          // R5 wrap up
        next_pc = 16'h0005; rel_off = 8'h80; issue(4'd3);          // R5 wrap down
        dptr = 16'hFFFF; acc = 8'h02; issue(4'd4);                 // R6 wrap
        chk("R2 drain", 32'(res_valid), 32'd1);
        @(negedge clk);
        chk("R2 idle after drain", 32'(res_valid), 32'd0);
        chk("R8 no clear when idle", 32'(bit_clear), 32'd0);
        test_bit = 1'b0; issue(4'd9);                              // R8 not taken
        test_bit = 1'b1; issue(4'd9);                              // R8 clear
        test_bit = 1'b1; issue(4'd7);                              // R8 no clear
        dec_src = 8'h01; issue(4'd13);                             // R11 falls through
        dec_src = 8'h00; issue(4'd13);                             // R11 wrap taken
        cmp_a = 8'h33; cmp_b = 8'h33; issue(4'd12);                // R10 equal
        cmp_a = 8'h10; cmp_b = 8'hF0; issue(4'd12);                // R10 less
        cmp_a = 8'hF0; cmp_b = 8'h10; issue(4'd12);                // R10 greater
        acc = 8'h00; issue(4'd10); issue(4'd11);                   // R9
        carry_in = 1'b1; issue(4'd5); issue(4'd6);                 // R7
        issue(4'd0); issue(4'd14); issue(4'd15);                   // R12

        // Random mix, with occasional idle gaps
        for (int i = 0; i < 400; i++) begin
            randomize_ops();
            issue(4'($urandom % 16));
            if ($urandom % 5 == 0) begin
                @(negedge clk);
                chk("R2 gap", 32'(res_valid), 32'd0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule